// File: doc/BRIEF.md
# Fan PWM Drive and Tachometer Counter

This block drives a cooling fan and measures its speed. Software programs an 8-bit duty value and a 15-bit divider through a small 32-bit register window. The block then produces a PWM waveform whose period is 256 × (divider + 1) system clocks. The waveform can be inverted, held at its inactive level by a gate bit, or sent out in open-collector form. In that form the pad is pulled low actively and released otherwise.

A tachometer input is synchronised and its rising edges are counted over windows of exactly `CLK_HZ` clocks, which is one second at the nominal clock. When a window closes, its total is copied into a read-only count register and counting starts again from zero. Duty and divider updates are buffered and take effect only when a full PWM period ends, so software writes cannot produce runt pulses.

Top module: `fan_pwm_tach`

## Requirements
- R1: After reset all three registers read zero, `pwm_o` is 0 and `pwm_oe_o` is 1.
- R2: The config word at byte address 0x0 holds the duty in bits [23:16], invert in bit 3, gate enable in bit 2, open-collector enable in bit 1 and a stored status flag in bit 0. All other bits read 0.
- R3: The divider word at 0x4 holds divider F in bits [14:0] and a stored 11-bit cycle field in bits [25:15]. All other bits read 0.
- R4: One PWM period lasts 256 × (F + 1) clocks, because an 8-bit phase advances once every F + 1 clocks.
- R5: With gate set, no inversion and push-pull output, the waveform is high for duty × (F + 1) clocks of each period. Duty 0 gives a constant low and duty 255 gives 255 × (F + 1) high clocks.
- R6: Invert set complements the level, so it is high for period − duty × (F + 1) clocks.
- R7: Gate cleared holds the level at its inactive value: 0, or 1 when invert is set.
- R8: Open-collector mode holds `pwm_o` at 0 and raises `pwm_oe_o` only while the level is low. In push-pull mode `pwm_oe_o` stays 1.
- R9: A new duty or divider value takes effect only when the current period ends, never within it.
- R10: Rising tach edges are counted over windows of `CLK_HZ` clocks. At each window end the total appears at 0xC bits [CNT_W-1:0] and the next window starts from zero.
- R11: An edge detected in the last clock of a window is counted in that window's total.
- R12: The window count saturates at 2^CNT_W − 1 (0xFFFF by default) instead of wrapping.
- R13: Writes to 0xC or to an unmapped address change nothing, and an unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Byte address, word aligned |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| tach_i | input | 1 | Asynchronous tachometer pulse input |
| pwm_o | output | 1 | PWM drive value |
| pwm_oe_o | output | 1 | Drive enable for the PWM pad |

## Verification
Two events can land in the same cycle: a tach edge and the close of a counting window. If that edge were lost, or counted in the next window, one window would be short by one. The bench drives a periodic tach signal whose period divides `CLK_HZ`, so every full window must hold exactly `CLK_HZ / period` edges. It then shifts the pulse train one clock at a time through every residue of the period, so that in one of these positions an edge falls on the closing cycle, and it requires the exact total at every shift. A register write landing mid-period is judged the same way: the output must keep the old duty until the period boundary.

// File: rtl/fan_pkg.sv
package fan_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int DUTY_W  = 8;
  localparam int DIV_W   = 15;
  localparam int CYC_W   = 11;
  localparam int DUTY_LSB = 16;
  localparam int CYC_LSB  = 15;

  typedef enum logic [1:0] {
    WSEL_CFG = 2'd0,
    WSEL_DIV = 2'd1,
    WSEL_NON = 2'd2,
    WSEL_CNT = 2'd3
  } wsel_e;
endpackage

// File: rtl/fan_regs.sv
module fan_regs
  import fan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [CNT_W-1:0]     cnt_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [DUTY_W-1:0]    duty_o,
  output logic                 inv_o,
  output logic                 gate_o,
  output logic                 oc_o,
  output logic [DIV_W-1:0]     div_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  wsel_e              wsel;
  logic               stat_q;
  logic [CYC_W-1:0]   cyc_q;
  logic               unused_bits;

  assign wsel        = wsel_e'(addr_i[3:2]);
  assign unused_bits = ^{addr_i[1:0], wdata_i[31:26], wdata_i[15:4]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_o <= '0;
      inv_o  <= 1'b0;
      gate_o <= 1'b0;
      oc_o   <= 1'b0;
      stat_q <= 1'b0;
      div_o  <= '0;
      cyc_q  <= '0;
    end else if (we_i) begin
      if (wsel == WSEL_CFG) begin
        duty_o <= wdata_i[DUTY_LSB +: DUTY_W];
        inv_o  <= wdata_i[3];
        gate_o <= wdata_i[2];
        oc_o   <= wdata_i[1];
        stat_q <= wdata_i[0];
      end
      if (wsel == WSEL_DIV) begin
        div_o <= wdata_i[DIV_W-1:0];
        cyc_q <= wdata_i[CYC_LSB +: CYC_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (wsel)
      WSEL_CFG: begin
        rdata_o[DUTY_LSB +: DUTY_W] = duty_o;
        rdata_o[3:0] = {inv_o, gate_o, oc_o, stat_q};
      end
      WSEL_DIV: begin
        rdata_o[DIV_W-1:0]          = div_o;
        rdata_o[CYC_LSB +: CYC_W]   = cyc_q;
      end
      WSEL_CNT: rdata_o = {{PAD_W{1'b0}}, cnt_i};
      default:  rdata_o = '0;
    endcase
  end

  // Config bits change only on a config write.
  assert_cfg_write_only_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(duty_o) |-> $past(we_i && addr_i[3:2] == 2'd0));
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              inv_i,
  input  logic              gate_i,
  input  logic              oc_i,
  output logic              pwm_o,
  output logic              pwm_oe_o
);
  localparam logic [DUTY_W-1:0] PH_LAST = '1;

  logic [DIV_W-1:0]  pre_q, div_act_q;
  logic [DUTY_W-1:0] phase_q, duty_act_q;
  logic              tick, wrap, raw, lvl;

  assign tick = (pre_q == div_act_q);
  assign wrap = tick && (phase_q == PH_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q      <= '0;
      phase_q    <= '0;
      div_act_q  <= '0;
      duty_act_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) phase_q <= phase_q + 1'b1;
      // shadow copies reload only at a period boundary
      if (wrap) begin
        div_act_q  <= div_i;
        duty_act_q <= duty_i;
      end
    end
  end

  assign raw = (phase_q < duty_act_q);
  assign lvl = (raw & gate_i) ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_o    <= 1'b0;
      pwm_oe_o <= 1'b1;
    end else begin
      pwm_o    <= oc_i ? 1'b0 : lvl;
      pwm_oe_o <= oc_i ? ~lvl : 1'b1;
    end
  end

  assert_prescale_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= div_act_q);
  assert_phase_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(phase_q));
  assert_shadow_at_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(duty_act_q) || !$stable(div_act_q)) |-> $past(wrap));
  assert_gate_inactive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!gate_i && !oc_i) |-> (pwm_o == $past(inv_i)));
  assert_oc_no_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(oc_i) |-> (pwm_o == 1'b0));
endmodule

// File: rtl/fan_tach_cnt.sv
module fan_tach_cnt #(
  parameter int CLK_HZ = 100_000_000,
  parameter int CNT_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tach_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int WIN_W = $clog2(CLK_HZ + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(CLK_HZ - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [2:0]       sync_q;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] acc_q, acc_nxt;
  logic             rise, win_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], tach_i};
  end

  assign rise    = sync_q[1] & ~sync_q[2];
  assign win_end = (win_q == WIN_LAST);
  assign acc_nxt = (rise && acc_q != CNT_MAX) ? acc_q + 1'b1 : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      acc_q <= '0;
      cnt_o <= '0;
    end else begin
      win_q <= win_end ? '0 : win_q + 1'b1;
      if (win_end) begin
        cnt_o <= acc_nxt;  // edge on closing cycle still counts
        acc_q <= '0;
      end else begin
        acc_q <= acc_nxt;
      end
    end
  end

  assert_sat_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q == CNT_MAX && !win_end) |=> (acc_q == CNT_MAX));
  assert_cnt_at_window_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_o) |-> $past(win_end));
  assert_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end |=> (acc_q == '0));
endmodule

// File: rtl/fan_pwm_tach.sv
module fan_pwm_tach
  import fan_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              tach_i,
  output logic              pwm_o,
  output logic              pwm_oe_o
);
  logic [DUTY_W-1:0] duty;
  logic [DIV_W-1:0]  div;
  logic              inv, gate, oc;
  logic [CNT_W-1:0]  cnt;

  fan_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .cnt_i   (cnt),
    .rdata_o (reg_rdata_o),
    .duty_o  (duty),
    .inv_o   (inv),
    .gate_o  (gate),
    .oc_o    (oc),
    .div_o   (div)
  );

  fan_pwm_gen u_pwm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .duty_i   (duty),
    .div_i    (div),
    .inv_i    (inv),
    .gate_i   (gate),
    .oc_i     (oc),
    .pwm_o    (pwm_o),
    .pwm_oe_o (pwm_oe_o)
  );

  fan_tach_cnt #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_tach (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tach_i (tach_i),
    .cnt_o  (cnt)
  );

  assert_oe_push_pull_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!oc) |-> pwm_oe_o);
endmodule

// File: tb/fan_pwm_tach_tb.sv
module fan_pwm_tach_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HZ  = 1200;
  localparam int CW  = 8;

  logic        clk = 0, rst_n = 0, we = 0, tach = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        pwm, pwm_oe;
  int checks = 0, fails = 0;
  int tach_per = 0, ph = 0;
  bit tach_hold = 0, done = 0;

  fan_pwm_tach #(.CLK_HZ(HZ), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tach_i(tach),
    .pwm_o(pwm), .pwm_oe_o(pwm_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    if (tach_per == 0) begin tach = 0; ph = 0; end
    else begin
      tach = (ph < tach_per/2);
      if (tach_hold) tach_hold = 0;
      else ph = (ph + 1) % tach_per;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic measure(int n, output int hi, output int oe_hi);
    hi = 0; oe_hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi += int'(pwm); oe_hi += int'(pwm_oe);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'h0, v); chk("R1 cfg", v, 0);
    rd(4'h4, v); chk("R1 div", v, 0);
    rd(4'hC, v); chk("R1 cnt", v, 0);
    chk("R1 pwm", pwm, 0);
    chk("R1 oe", pwm_oe, 1);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, v); chk("R2 cfg fields", v, 32'h00FF_000F);
    wr(4'h0, 32'h00A5_0005); rd(4'h0, v); chk("R2 cfg pattern", v, 32'h00A5_0005);
    wr(4'h4, 32'hFFFF_FFFF); rd(4'h4, v); chk("R3 div fields", v, 32'h03FF_FFFF);
    wr(4'h4, 32'h0000_8003); rd(4'h4, v); chk("R3 cycle lsb", v, 32'h0000_8003);
    wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, v); chk("R13 unmapped read", v, 0);
    rd(4'h0, v); chk("R13 cfg kept", v, 32'h00A5_0005);
    rd(4'h4, v); chk("R13 div kept", v, 32'h0000_8003);
    wr(4'hC, 32'h0000_FFFF); rd(4'hC, v); chk("R13 cnt read-only", v, 0);
    wr(4'h0, 0); wr(4'h4, 0);
  endtask

  task automatic t_pwm(string req, int duty, int f, bit inv, bit gate, bit oc);
    int per, lvl, hi, oeh;
    per = 256 * (f + 1);
    wr(4'h4, f);
    wr(4'h0, (duty << 16) | (inv << 3) | (gate << 2) | (oc << 1));
    repeat (2 * per + 4) @(negedge clk);
    if (gate) lvl = inv ? per - duty * (f + 1) : duty * (f + 1);
    else      lvl = inv ? per : 0;
    measure(per, hi, oeh);
    chk({req, " high clocks"}, hi, oc ? 0 : lvl);
    chk({req, " oe clocks"}, oeh, oc ? per - lvl : per);
  endtask

  task automatic t_shadow();
    int hi, oeh, lows;
    logic prev;
    t_pwm("R9 setup", 100, 0, 0, 1, 0);
    prev = 1;
    forever begin
      @(negedge clk);
      if (pwm && !prev) break;
      prev = pwm;
    end
    repeat (150) @(negedge clk);
    wr(4'h0, (200 << 16) | (1 << 2));
    lows = 0;
    for (int i = 0; i < 80; i++) begin @(negedge clk); lows += int'(!pwm); end
    chk("R9 no change mid-period", lows, 80);
    repeat (300) @(negedge clk);
    measure(256, hi, oeh);
    chk("R9 new duty after boundary", hi, 200);
  endtask

  task automatic tach_window(string req, int per, int exp);
    logic [31:0] v;
    tach_per = per;
    repeat (2 * HZ + 8) @(negedge clk);
    rd(4'hC, v); chk(req, v, exp);
  endtask

  task automatic t_tach();
    logic [31:0] v;
    tach_window("R10 period 10", 10, HZ / 10);
    tach_window("R10 period 6", 6, HZ / 6);
    // shift the pulse train through all residues so one edge hits the window end
    tach_per = 10;
    for (int k = 0; k < 10; k++) begin
      tach_hold = 1;
      repeat (2 * HZ + 8) @(negedge clk);
      rd(4'hC, v); chk($sformatf("R11 shift %0d", k), v, HZ / 10);
    end
    tach_window("R12 saturate", 2, (1 << CW) - 1);
    tach_window("R10 restart after saturation", 6, HZ / 6);
    tach_window("R10 no pulses", 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regmap();
    t_pwm("R5 R4 duty64 f0", 64, 0, 0, 1, 0);
    t_pwm("R4 duty64 f2", 64, 2, 0, 1, 0);
    t_pwm("R5 duty0", 0, 0, 0, 1, 0);
    t_pwm("R5 duty255 f1", 255, 1, 0, 1, 0);
    t_pwm("R6 invert", 64, 0, 1, 1, 0);
    t_pwm("R7 gate off", 100, 0, 0, 0, 0);
    t_pwm("R7 gate off inverted", 100, 0, 1, 0, 0);
    t_pwm("R8 open collector", 64, 0, 0, 1, 1);
    t_pwm("R8 open collector inverted", 64, 1, 1, 1, 1);
    t_shadow();
    t_tach();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule